// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Aggregator

This block sits beside the 64 message buffers of a CAN controller. It turns one-cycle completion pulses into sticky per-buffer flags and gates each flag with a software mask. The masked flags become interrupt lines: buffers 0 to 15 each have a dedicated line, buffers 16 to 31 share one OR line, and buffers 32 to 63 share another. Twenty interrupt outputs therefore cover 64 buffer sources plus the error and bus-state events.

Error events and bus-off, transmit-warning and receive-warning events are held in a sticky status register. An error interrupt and a combined bus/warning interrupt are each enabled by a bit in a control register. Software reaches flags, masks, status and control through a word-wide write port and a combinational read port. Flags and status bits are cleared by writing 1 and are unaffected by writing 0. A hardware set in the same cycle as a software clear keeps the bit set. All interrupt outputs are registered, level-sensitive and active high.

Top module: `mb_irq_collector`

## Requirements
- R1: After reset, every flag, mask, status and control bit reads 0 and every interrupt output is low.
- R2: A pulse on `done_pulse[i]` sets flag i. Flags for buffers 0..31 read at address 0, bit i. Flags for buffers 32..63 read at address 1, bit i-32. TX and RX completions share this one flag.
- R3: A write to address 0, 1 or 4 clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: A set event and a write-1 clear that hit the same flag or status bit in the same clock cycle leave the bit set.
- R5: Address 2 (buffers 0..31) and address 3 (buffers 32..63) are read/write mask registers. For i < 16, `irq_buf[i]` equals (flag i AND mask i) as it stood before the previous clock edge.
- R6: `irq_grp_lo` is the OR over buffers 16..31 of (flag AND mask), registered one cycle after the state it reflects.
- R7: `irq_grp_hi` is the OR over buffers 32..63 of (flag AND mask), registered one cycle after the state it reflects.
- R8: The status register is at address 4. Bit 0 is error, bit 1 is bus-off, bit 2 is transmit warning and bit 3 is receive warning. Each bit is set by its event pulse and is sticky until cleared by writing 1.
- R9: The control register is at address 5, read/write on bits 1:0. `irq_err` is (status bit 0 AND control bit 0). `irq_bus` is (OR of status bits 3:1 AND control bit 1). Both are registered one cycle after the state they reflect.
- R10: Addresses 6 and 7, and control bits 31:2, read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_pulse | input | 64 | Per-buffer successful completion pulse |
| evt_err | input | 1 | Error event pulse |
| evt_busoff | input | 1 | Bus-off event pulse |
| evt_txwarn | input | 1 | Transmit-warning event pulse |
| evt_rxwarn | input | 1 | Receive-warning event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_buf | output | 16 | Dedicated interrupts for buffers 0..15 |
| irq_grp_lo | output | 1 | Grouped interrupt for buffers 16..31 |
| irq_grp_hi | output | 1 | Grouped interrupt for buffers 32..63 |
| irq_err | output | 1 | Error interrupt |
| irq_bus | output | 1 | Bus-off / warning interrupt |

## Verification
Random completion pulses are sparse and land anywhere in the 64 buffers. Masks are random words. Under this mix, a misrouted bit shows up as a wrong dedicated line versus a wrong group line, and a swapped group boundary is visible at buffers 15/16 and 31/32. Random writes of random data to all eight addresses separate write-1-clear from plain overwrite and catch writes that leak into unmapped space. Directed cycles put a set and a clear on the same bit to expose the priority. Directed cycles also raise each warning event alone with the bus enable toggled, which shows whether all three warnings feed the combined line.

// File: rtl/mb_irq_collector.sv
module mb_irq_collector #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int NDED = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] done_pulse,
  input  logic            evt_err,
  input  logic            evt_busoff,
  input  logic            evt_txwarn,
  input  logic            evt_rxwarn,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NDED-1:0] irq_buf,
  output logic            irq_grp_lo,
  output logic            irq_grp_hi,
  output logic            irq_err,
  output logic            irq_bus
);
  localparam logic [AW-1:0] A_FLO = 0, A_FHI = 1, A_MLO = 2, A_MHI = 3,
                            A_STS = 4, A_CTL = 5;

  logic [DW-1:0] flag_lo, flag_hi, mask_lo, mask_hi;
  logic [3:0]    sts;
  logic [1:0]    ctl;

  wire [DW-1:0] clr_lo  = (reg_we && reg_addr == A_FLO) ? reg_wdata : '0;
  wire [DW-1:0] clr_hi  = (reg_we && reg_addr == A_FHI) ? reg_wdata : '0;
  wire [3:0]    clr_sts = (reg_we && reg_addr == A_STS) ? reg_wdata[3:0] : '0;
  wire [3:0]    set_sts = {evt_rxwarn, evt_txwarn, evt_busoff, evt_err};

  wire [DW-1:0] act_lo = flag_lo & mask_lo;
  wire [DW-1:0] act_hi = flag_hi & mask_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lo <= '0;
      flag_hi <= '0;
      mask_lo <= '0;
      mask_hi <= '0;
      sts     <= '0;
      ctl     <= '0;
    end else begin
      flag_lo <= (flag_lo & ~clr_lo) | done_pulse[DW-1:0];
      flag_hi <= (flag_hi & ~clr_hi) | done_pulse[2*DW-1:DW];
      sts     <= (sts & ~clr_sts) | set_sts;
      if (reg_we && reg_addr == A_MLO) mask_lo <= reg_wdata;
      if (reg_we && reg_addr == A_MHI) mask_hi <= reg_wdata;
      if (reg_we && reg_addr == A_CTL) ctl <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_buf    <= '0;
      irq_grp_lo <= 1'b0;
      irq_grp_hi <= 1'b0;
      irq_err    <= 1'b0;
      irq_bus    <= 1'b0;
    end else begin
      irq_buf    <= act_lo[NDED-1:0];
      irq_grp_lo <= |act_lo[DW-1:NDED];
      irq_grp_hi <= |act_hi;
      irq_err    <= sts[0] & ctl[0];
      irq_bus    <= (|sts[3:1]) & ctl[1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FLO:   reg_rdata = flag_lo;
      A_FHI:   reg_rdata = flag_hi;
      A_MLO:   reg_rdata = mask_lo;
      A_MHI:   reg_rdata = mask_hi;
      A_STS:   reg_rdata[3:0] = sts;
      A_CTL:   reg_rdata[1:0] = ctl;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mb_irq_collector_chk.sv
module mb_irq_collector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] done_pulse,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] flag_lo,
  input logic [31:0] mask_lo,
  input logic [31:0] flag_hi,
  input logic [31:0] mask_hi,
  input logic [3:0]  sts,
  input logic [1:0]  ctl,
  input logic [15:0] irq_buf,
  input logic        irq_grp_lo,
  input logic        irq_grp_hi,
  input logic        irq_err,
  input logic        irq_bus
);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_lo & $past(done_pulse[31:0])) == $past(done_pulse[31:0])) &&
             ((flag_hi & $past(done_pulse[63:32])) == $past(done_pulse[63:32])));

  p_keep_unwritten_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd0) |=> (($past(flag_lo) & ~flag_lo) == 32'd0));

  p_dedicated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_buf == $past(flag_lo[15:0] & mask_lo[15:0]));

  p_group_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_grp_lo == $past(|(flag_lo[31:16] & mask_lo[31:16])));

  p_group_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_grp_hi == $past(|(flag_hi & mask_hi)));

  p_bus_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_bus == $past((|sts[3:1]) & ctl[1]));

  p_sticky_sts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd4) |=> (($past(sts) & ~sts) == 4'd0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr >= 3'd6) |=> $stable(mask_lo) && $stable(mask_hi) && $stable(ctl));
endmodule

bind mb_irq_collector mb_irq_collector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flag_lo(flag_lo), .mask_lo(mask_lo),
  .flag_hi(flag_hi), .mask_hi(mask_hi), .sts(sts), .ctl(ctl), .irq_buf(irq_buf),
  .irq_grp_lo(irq_grp_lo), .irq_grp_hi(irq_grp_hi), .irq_err(irq_err), .irq_bus(irq_bus)
);

// File: tb/tb_mb_irq_collector.sv
module tb_mb_irq_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] done_pulse = '0;
  logic        evt_err = 0, evt_busoff = 0, evt_txwarn = 0, evt_rxwarn = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_buf;
  logic        irq_grp_lo, irq_grp_hi, irq_err, irq_bus;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [63:0] m_flag = '0, m_mask = '0;
  logic [3:0]  m_sts = '0;
  logic [1:0]  m_ctl = '0;

  always #10 clk = ~clk;

  mb_irq_collector dut (.*);

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_flag[31:0];
      3'd1: return m_flag[63:32];
      3'd2: return m_mask[31:0];
      3'd3: return m_mask[63:32];
      3'd4: return {28'd0, m_sts};
      3'd5: return {30'd0, m_ctl};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2/R3";
      3'd2, 3'd3: return "R5";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [63:0] d, input logic [3:0] ev, input logic we,
                      input logic [2:0] a, input logic [31:0] wd);
    logic [63:0] act;
    logic [15:0] e_buf;
    logic e_glo, e_ghi, e_err, e_bus;
    logic [63:0] clr;
    @(negedge clk);
    done_pulse = d;
    {evt_rxwarn, evt_txwarn, evt_busoff, evt_err} = ev;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    act   = m_flag & m_mask;
    e_buf = act[15:0];
    e_glo = |act[31:16];
    e_ghi = |act[63:32];
    e_err = m_sts[0] & m_ctl[0];
    e_bus = (|m_sts[3:1]) & m_ctl[1];
    clr = '0;
    if (we && a == 3'd0) clr[31:0]  = wd;
    if (we && a == 3'd1) clr[63:32] = wd;
    m_flag = (m_flag & ~clr) | d;
    m_sts  = (m_sts & ~((we && a == 3'd4) ? wd[3:0] : 4'd0)) | ev;
    if (we && a == 3'd2) m_mask[31:0]  = wd;
    if (we && a == 3'd3) m_mask[63:32] = wd;
    if (we && a == 3'd5) m_ctl = wd[1:0];
    #1;
    check("R5 irq_buf", {48'd0, irq_buf}, {48'd0, e_buf});
    check("R6 irq_grp_lo", {63'd0, irq_grp_lo}, {63'd0, e_glo});
    check("R7 irq_grp_hi", {63'd0, irq_grp_hi}, {63'd0, e_ghi});
    check("R9 irq_err", {63'd0, irq_err}, {63'd0, e_err});
    check("R9 irq_bus", {63'd0, irq_bus}, {63'd0, e_bus});
    check(rtag(a), {32'd0, reg_rdata}, {32'd0, m_read(a)});
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #45 rst_n = 1'b1;
    // R1: reset state on outputs and every address
    #1;
    check("R1 outputs", {44'd0, irq_buf, irq_grp_lo, irq_grp_hi, irq_err, irq_bus}, 64'd0);
    for (int a = 0; a < 8; a++) step('0, 4'd0, 1'b0, 3'(a), '0);

    // R5/R6/R7 boundary: buffers 15, 16, 31, 32 with full masks
    step('0, 0, 1, 3'd2, 32'hFFFF_FFFF);
    step('0, 0, 1, 3'd3, 32'hFFFF_FFFF);
    step(64'h1 << 15, 0, 0, 3'd0, '0);
    step(64'h1 << 16, 0, 0, 3'd0, '0);
    step('0, 0, 1, 3'd0, 32'h0000_8000);
    step('0, 0, 0, 3'd0, '0);
    check("R6 buffer16 alone", {63'd0, irq_grp_lo}, 64'd1);
    step(64'h1 << 32, 0, 1, 3'd0, 32'h0001_0000);
    step('0, 0, 0, 3'd1, '0);
    check("R7 buffer32 alone", {62'd0, irq_grp_lo, irq_grp_hi}, 64'd1);
    step('0, 0, 1, 3'd1, 32'h0000_0001);
    step(64'h1 << 31, 0, 0, 3'd0, '0);
    step('0, 0, 0, 3'd0, '0);
    check("R6 buffer31", {62'd0, irq_grp_lo, irq_grp_hi}, 64'd2);

    // R4: set and clear on the same bit in the same cycle
    step(64'h1 << 5, 0, 0, 3'd0, '0);
    step(64'h1 << 5, 0, 1, 3'd0, 32'h0000_0020);
    check("R4 flag kept", {32'd0, reg_rdata & 32'h20}, 64'h20);
    step('0, 4'b0001, 1, 3'd4, 32'h1);
    step('0, 4'b0001, 1, 3'd4, 32'h1);
    check("R4 status kept", {32'd0, reg_rdata & 32'h1}, 64'h1);
    // R3: write 0 keeps, write 1 clears
    step('0, 0, 1, 3'd0, 32'h0);
    check("R3 write0 keeps", {32'd0, reg_rdata & 32'h20}, 64'h20);
    step('0, 0, 1, 3'd0, 32'hFFFF_FFFF);
    check("R3 write1 clears", {32'd0, reg_rdata}, 64'd0);

    // R8/R9: each warning alone drives the bus line when enabled
    step('0, 0, 1, 3'd4, 32'hF);
    step('0, 0, 1, 3'd5, 32'h2);
    for (int w = 1; w < 4; w++) begin
      step('0, 4'(1 << w), 0, 3'd4, '0);
      step('0, 0, 0, 3'd4, '0);
      check("R8 sticky warning", {32'd0, reg_rdata}, 64'(1 << w));
      check("R9 bus line", {63'd0, irq_bus}, 64'd1);
      step('0, 0, 1, 3'd4, 32'hF);
      step('0, 0, 0, 3'd4, '0);
    end

    // R10: writes to unmapped addresses and upper control bits
    step('0, 0, 1, 3'd6, 32'hFFFF_FFFF);
    step('0, 0, 1, 3'd7, 32'hFFFF_FFFF);
    step('0, 0, 1, 3'd5, 32'hFFFF_FFFC);
    check("R10 control upper bits", {32'd0, reg_rdata}, 64'd0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] d;
      logic [3:0] ev;
      d  = {$urandom & $urandom & $urandom & $urandom, $urandom & $urandom & $urandom & $urandom};
      ev = 4'($urandom & $urandom & $urandom);
      step(d, ev, ($urandom % 3) == 0, 3'($urandom), $urandom);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule